// File: doc/BRIEF.md
# Memory Operand Effective Address Unit

This unit turns the already-decoded addressing bytes of one instruction into the address of its memory operand. It takes the optional prefix byte that widens register numbers, the ModR/M byte, the SIB byte and a displacement field of up to 32 bits. It also takes the address of the following instruction and two mode inputs: one for the 64-bit operating mode and one for the address-size override. It reads up to two general registers from a sixteen-entry register file through two combinational read ports, one for the base and one for the index.

The address is formed as base plus scaled index plus sign-extended displacement. In 64-bit mode the pure-displacement encoding becomes relative to the next instruction's address, and the unit raises a flag when that happens. When the ModR/M byte names a register instead of memory, the unit reports the register number and forms no address. Each result is captured one cycle after a valid strobe and presented with its own valid flag. 16-bit addressing, segment bases and instruction fetch are outside the block.

Top module: `modrm_ea_unit`

## Requirements
- R1: When mod (ModR/M bits 7:6) is 11, out_is_reg is 1 and out_reg_idx is {extension bit B, r/m (bits 2:0)}. out_ea is zero and out_rip_rel is 0.
- R2: With r/m not 100, and not the mod=00/r/m=101 form, the base is register {B, r/m}. Under mod=00 there is no displacement. Under mod=01, disp bits 7:0 are sign-extended and added. Under mod=10, disp bits 31:0 are sign-extended and added.
- R3: When r/m is 100 and mod is not 11, the SIB byte is used. The address is register {B, SIB[2:0]} plus (register {X, SIB[5:3]} shifted left by SIB[7:6]) plus the displacement chosen by mod. An index code {X, SIB[5:3]} of 0100 contributes nothing, while 1100 selects register 12.
- R4: A SIB base field of 101 under mod=00 means no base register and a sign-extended 32-bit displacement, whatever the value of B.
- R5: In 64-bit mode, mod=00 with r/m=101 gives next_ip plus sign-extended disp[31:0] and sets out_rip_rel. This holds even when B is 1.
- R6: Register 13 with no offset is reached by mod=01, r/m=101, B=1 and an 8-bit displacement of zero, and the result equals register 13.
- R7: In 64-bit mode the address-size override keeps the instruction-relative form, including its flag. It also truncates the sum to its low 32 bits and zero-extends it.
- R8: Outside 64-bit mode, mod=00 with r/m=101 is a displacement-only address with out_rip_rel 0. Every address is reduced to 32 bits and zero-extended. The prefix byte and the override are ignored.
- R9: After reset, out_valid, out_ea, out_is_reg, out_reg_idx and out_rip_rel are zero. out_valid is 1 exactly one cycle after each cycle with in_valid high, and 0 otherwise.
- R10: The extension bits come from rex_byte bit 0 (B) and bit 1 (X), and only when rex_present is 1. When rex_present is 0 they are treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: addressing inputs are valid this cycle |
| rex_present | input | 1 | Register-extension prefix byte is present |
| rex_byte | input | 8 | Register-extension prefix byte |
| modrm | input | 8 | ModR/M byte |
| sib | input | 8 | SIB byte |
| disp | input | 32 | Displacement field, low bits used for 8-bit form |
| next_ip | input | 64 | Address of the following instruction |
| long_mode | input | 1 | 64-bit operating mode |
| asz_override | input | 1 | Address-size override prefix seen |
| rd_base_sel | output | 4 | Register file read index for the base |
| rd_base_data | input | 64 | Register file data for rd_base_sel, same cycle |
| rd_index_sel | output | 4 | Register file read index for the index |
| rd_index_data | input | 64 | Register file data for rd_index_sel, same cycle |
| out_valid | output | 1 | Result valid |
| out_ea | output | 64 | Effective address |
| out_is_reg | output | 1 | Operand is a register, no address formed |
| out_reg_idx | output | 4 | Register number when out_is_reg is 1 |
| out_rip_rel | output | 1 | Address was formed relative to next_ip |

## Verification
The assertions assume that every addressing input, and the register file contents seen through the two read ports, are known and stable in any cycle where in_valid is high. They also assume that the register file answers in the same cycle as the select. The bench keeps to this by modelling the register file as a fixed function of the register number, evaluated combinationally from the select outputs. It changes inputs only on the falling clock edge. The sweep covers every ModR/M value under each mode and override setting, with prefix and SIB values picked to reach the no-index, no-base, register-12 index and register-13 base cases.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;

   localparam logic [1:0] MOD_MEM_NODISP = 2'b00;
   localparam logic [1:0] MOD_MEM_D8     = 2'b01;
   localparam logic [1:0] MOD_MEM_D32    = 2'b10;
   localparam logic [1:0] MOD_REG        = 2'b11;
   localparam logic [2:0] RM_USES_SIB    = 3'b100;
   localparam logic [2:0] RM_BARE_DISP   = 3'b101;
   localparam logic [2:0] SIB_NO_BASE    = 3'b101;
   localparam logic [3:0] IDX_ABSENT     = 4'b0100;

   typedef enum logic [1:0] {
      DISP_NONE  = 2'd0,
      DISP_SHORT = 2'd1,
      DISP_LONG  = 2'd2
   } disp_kind_e;

   typedef struct packed {
      logic       is_reg;
      logic [3:0] reg_idx;
      logic       base_en;
      logic [3:0] base_sel;
      logic       idx_en;
      logic [3:0] idx_sel;
      logic [1:0] scale;
      disp_kind_e dkind;
      logic       rip_rel;
      logic       narrow;
   } ea_plan_t;

endpackage

// File: rtl/agu_decode.sv
`timescale 1ns/1ps
module agu_decode
   import agu_pkg::*;
(
   input  logic       rex_present,
   input  logic [7:0] rex_byte,
   input  logic [7:0] modrm,
   input  logic [7:0] sib,
   input  logic       long_mode,
   input  logic       asz_override,
   output ea_plan_t   plan
);

   logic       rex_b;
   logic       rex_x;
   logic [1:0] mod_f;
   logic [2:0] rm_f;
   logic [2:0] sbase_f;
   logic [2:0] sidx_f;
   logic [1:0] sscale_f;
   logic [3:0] idx_full;
   logic [8:0] unused_fields;

   assign rex_b         = rex_present & long_mode & rex_byte[0];
   assign rex_x         = rex_present & long_mode & rex_byte[1];
   assign mod_f         = modrm[7:6];
   assign rm_f          = modrm[2:0];
   assign sbase_f       = sib[2:0];
   assign sidx_f        = sib[5:3];
   assign sscale_f      = sib[7:6];
   assign idx_full      = {rex_x, sidx_f};
   assign unused_fields = {rex_byte[7:2], modrm[5:3]};

   function automatic disp_kind_e kind_for_mod(input logic [1:0] m);
      case (m)
         MOD_MEM_D8:  return DISP_SHORT;
         MOD_MEM_D32: return DISP_LONG;
         default:     return DISP_NONE;
      endcase
   endfunction

   always_comb begin
      plan        = '0;
      plan.dkind  = DISP_NONE;
      plan.narrow = ~long_mode | asz_override;
      if (mod_f == MOD_REG) begin
         plan.is_reg  = 1'b1;
         plan.reg_idx = {rex_b, rm_f};
         plan.narrow  = 1'b0;
      end else if (rm_f == RM_USES_SIB) begin
         plan.base_sel = {rex_b, sbase_f};
         plan.base_en  = !((mod_f == MOD_MEM_NODISP) && (sbase_f == SIB_NO_BASE));
         plan.idx_sel  = idx_full;
         plan.idx_en   = (idx_full != IDX_ABSENT);
         plan.scale    = sscale_f;
         if (mod_f == MOD_MEM_NODISP)
            plan.dkind = plan.base_en ? DISP_NONE : DISP_LONG;
         else
            plan.dkind = kind_for_mod(mod_f);
      end else if ((mod_f == MOD_MEM_NODISP) && (rm_f == RM_BARE_DISP)) begin
         plan.base_en = 1'b0;
         plan.dkind   = DISP_LONG;
         plan.rip_rel = long_mode;
      end else begin
         plan.base_en  = 1'b1;
         plan.base_sel = {rex_b, rm_f};
         plan.dkind    = kind_for_mod(mod_f);
      end
   end

endmodule

// File: rtl/agu_disp_ext.sv
`timescale 1ns/1ps
module agu_disp_ext
   import agu_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int DISP_W  = 32,
   parameter int SHORT_W = 8
) (
   input  logic [DISP_W-1:0] disp,
   input  disp_kind_e        kind,
   output logic [ADDR_W-1:0] disp_ext
);

   localparam int LONG_PAD  = ADDR_W - DISP_W;
   localparam int SHORT_PAD = ADDR_W - SHORT_W;

   generate
      if (DISP_W <= SHORT_W) begin : g_bad_short
         $error("agu_disp_ext: DISP_W must exceed SHORT_W");
      end
      if (ADDR_W <= DISP_W) begin : g_bad_addr
         $error("agu_disp_ext: ADDR_W must exceed DISP_W");
      end
   endgenerate

   logic [ADDR_W-1:0] short_ext;
   logic [ADDR_W-1:0] long_ext;

   assign short_ext = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
   assign long_ext  = {{LONG_PAD{disp[DISP_W-1]}}, disp};

   always_comb begin
      case (kind)
         DISP_SHORT: disp_ext = short_ext;
         DISP_LONG:  disp_ext = long_ext;
         default:    disp_ext = '0;
      endcase
   end

endmodule

// File: rtl/agu_combine.sv
`timescale 1ns/1ps
module agu_combine
   import agu_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32
) (
   input  ea_plan_t          plan,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] idx_val,
   input  logic [ADDR_W-1:0] next_ip,
   input  logic [ADDR_W-1:0] disp_ext,
   output logic [ADDR_W-1:0] ea
);

   logic [ADDR_W-1:0] base_term;
   logic [ADDR_W-1:0] idx_term;
   logic [ADDR_W-1:0] full_sum;

   always_comb begin
      if (plan.rip_rel)
         base_term = next_ip;
      else if (plan.base_en)
         base_term = base_val;
      else
         base_term = '0;
   end

   always_comb begin
      if (!plan.idx_en)
         idx_term = '0;
      else begin
         case (plan.scale)
            2'd0:    idx_term = idx_val;
            2'd1:    idx_term = {idx_val[ADDR_W-2:0], 1'b0};
            2'd2:    idx_term = {idx_val[ADDR_W-3:0], 2'b0};
            default: idx_term = {idx_val[ADDR_W-4:0], 3'b0};
         endcase
      end
   end

   assign full_sum = base_term + idx_term + disp_ext;

   generate
      if (ADDR_W > NARROW_W) begin : g_narrowing
         localparam int HI_W = ADDR_W - NARROW_W;
         always_comb begin
            if (plan.is_reg)
               ea = '0;
            else if (plan.narrow)
               ea = {{HI_W{1'b0}}, full_sum[NARROW_W-1:0]};
            else
               ea = full_sum;
         end
      end else begin : g_flat
         always_comb ea = plan.is_reg ? '0 : full_sum;
      end
   endgenerate

endmodule

// File: rtl/modrm_ea_unit.sv
`timescale 1ns/1ps
module modrm_ea_unit
   import agu_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32,
   parameter int DISP_W   = 32,
   parameter int SHORT_W  = 8,
   parameter int NREG     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              rex_present,
   input  logic [7:0]        rex_byte,
   input  logic [7:0]        modrm,
   input  logic [7:0]        sib,
   input  logic [31:0]       disp,
   input  logic [ADDR_W-1:0] next_ip,
   input  logic              long_mode,
   input  logic              asz_override,
   output logic [3:0]        rd_base_sel,
   input  logic [ADDR_W-1:0] rd_base_data,
   output logic [3:0]        rd_index_sel,
   input  logic [ADDR_W-1:0] rd_index_data,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_ea,
   output logic              out_is_reg,
   output logic [3:0]        out_reg_idx,
   output logic              out_rip_rel
);

   localparam int SEL_W = $clog2(NREG);

   generate
      if (NREG != 16 || SEL_W != 4) begin : g_bad_nreg
         $error("modrm_ea_unit: extended register numbering needs NREG == 16");
      end
      if (DISP_W != 32) begin : g_bad_disp
         $error("modrm_ea_unit: displacement port is 32 bits wide");
      end
      if (NARROW_W >= ADDR_W) begin : g_bad_narrow
         $error("modrm_ea_unit: NARROW_W must be below ADDR_W");
      end
   endgenerate

   ea_plan_t          plan;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] ea_comb;

   agu_decode u_decode (
      .rex_present  (rex_present),
      .rex_byte     (rex_byte),
      .modrm        (modrm),
      .sib          (sib),
      .long_mode    (long_mode),
      .asz_override (asz_override),
      .plan         (plan)
   );

   assign rd_base_sel  = plan.base_sel;
   assign rd_index_sel = plan.idx_sel;

   agu_disp_ext #(
      .ADDR_W  (ADDR_W),
      .DISP_W  (DISP_W),
      .SHORT_W (SHORT_W)
   ) u_disp (
      .disp     (disp),
      .kind     (plan.dkind),
      .disp_ext (disp_ext)
   );

   agu_combine #(
      .ADDR_W   (ADDR_W),
      .NARROW_W (NARROW_W)
   ) u_combine (
      .plan     (plan),
      .base_val (rd_base_data),
      .idx_val  (rd_index_data),
      .next_ip  (next_ip),
      .disp_ext (disp_ext),
      .ea       (ea_comb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_ea      <= '0;
         out_is_reg  <= 1'b0;
         out_reg_idx <= '0;
         out_rip_rel <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ea      <= ea_comb;
            out_is_reg  <= plan.is_reg;
            out_reg_idx <= plan.reg_idx;
            out_rip_rel <= plan.rip_rel;
         end
      end
   end

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R1
   reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && modrm[7:6] == MOD_REG)
      |=> (out_is_reg && out_ea == '0 && !out_rip_rel));

   // R5
   rip_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && long_mode && modrm[7:6] == MOD_MEM_NODISP && modrm[2:0] == RM_BARE_DISP)
      |=> (out_rip_rel && !out_is_reg));

   // R8
   legacy_no_rip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !long_mode) |=> !out_rip_rel);

   // R7
   narrow_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (!long_mode || asz_override))
      |=> (out_ea[ADDR_W-1:NARROW_W] == '0));

endmodule

// File: tb/modrm_ea_unit_bench.sv
`timescale 1ns/1ps
module modrm_ea_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        rex_present = 1'b0;
   logic [7:0]  rex_byte = '0;
   logic [7:0]  modrm = '0;
   logic [7:0]  sib = '0;
   logic [31:0] disp = '0;
   logic [63:0] next_ip = '0;
   logic        long_mode = 1'b0;
   logic        asz_override = 1'b0;
   logic [3:0]  rd_base_sel;
   logic [63:0] rd_base_data;
   logic [3:0]  rd_index_sel;
   logic [63:0] rd_index_data;
   logic        out_valid;
   logic [63:0] out_ea;
   logic        out_is_reg;
   logic [3:0]  out_reg_idx;
   logic        out_rip_rel;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [63:0] regval(input logic [3:0] i);
      return 64'hF0E1_D2C3_0000_0000 + {60'd0, i} * 64'h0000_0101_1357_9BDF;
   endfunction

   assign rd_base_data  = regval(rd_base_sel);
   assign rd_index_data = regval(rd_index_sel);

   modrm_ea_unit u_modrm_ea_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .rex_present   (rex_present),
      .rex_byte      (rex_byte),
      .modrm         (modrm),
      .sib           (sib),
      .disp          (disp),
      .next_ip       (next_ip),
      .long_mode     (long_mode),
      .asz_override  (asz_override),
      .rd_base_sel   (rd_base_sel),
      .rd_base_data  (rd_base_data),
      .rd_index_sel  (rd_index_sel),
      .rd_index_data (rd_index_data),
      .out_valid     (out_valid),
      .out_ea        (out_ea),
      .out_is_reg    (out_is_reg),
      .out_reg_idx   (out_reg_idx),
      .out_rip_rel   (out_rip_rel)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(
      input  logic lm, input logic asz, input logic rp, input logic [7:0] rx,
      input  logic [7:0] mr, input logic [7:0] sb, input logic [31:0] dp,
      input  logic [63:0] nip,
      output logic [63:0] ea, output logic isr, output logic [3:0] ridx,
      output logic rip, output string tag);
      logic       b, x;
      logic [1:0] md;
      logic [2:0] rm;
      logic [63:0] d8, d32, d, acc;
      logic [3:0] ii;
      bit has_base;
      b   = rp & lm & rx[0];
      x   = rp & lm & rx[1];
      md  = mr[7:6];
      rm  = mr[2:0];
      d8  = {{56{dp[7]}}, dp[7:0]};
      d32 = {{32{dp[31]}}, dp};
      d   = (md == 2'b01) ? d8 : (md == 2'b10) ? d32 : 64'd0;
      ea = '0; isr = 1'b0; ridx = '0; rip = 1'b0; tag = "R2";
      acc = '0;
      if (md == 2'b11) begin
         isr = 1'b1; ridx = {b, rm}; tag = "R1";
         return;
      end
      if (rm == 3'b100) begin
         has_base = !(md == 2'b00 && sb[2:0] == 3'b101);
         if (!has_base) d = d32;
         ii  = {x, sb[5:3]};
         acc = (has_base ? regval({b, sb[2:0]}) : 64'd0) + d
             + ((ii == 4'b0100) ? 64'd0 : regval(ii) * (64'd1 << sb[7:6]));
         tag = has_base ? "R3" : "R4";
      end else if (md == 2'b00 && rm == 3'b101) begin
         if (lm) begin
            acc = nip + d32; rip = 1'b1; tag = asz ? "R7" : "R5";
         end else
            acc = d32;
      end else
         acc = regval({b, rm}) + d;
      if (!lm || asz) acc = {32'd0, acc[31:0]};
      if (!lm) tag = "R8";
      else if (!rp) tag = "R10";
      ea = acc;
   endfunction

   logic [63:0] e_ea;
   logic        e_isr, e_rip;
   logic [3:0]  e_ridx;
   string       e_tag;
   bit          pend = 1'b0;

   task automatic check_pending();
      if (pend) begin
         chk(out_valid === 1'b1, "R9", "valid", {63'd0, out_valid}, 64'd1);
         chk(out_ea === e_ea, e_tag, "address", out_ea, e_ea);
         chk(out_is_reg === e_isr && (!e_isr || out_reg_idx === e_ridx), e_tag,
             "register operand", {59'd0, out_is_reg, out_reg_idx},
             {59'd0, e_isr, e_ridx});
         chk(out_rip_rel === e_rip, e_tag, "relative flag",
             {63'd0, out_rip_rel}, {63'd0, e_rip});
      end
      pend = 1'b0;
   endtask

   task automatic run_op(input logic lm, input logic asz, input logic rp,
                         input logic [7:0] rx, input logic [7:0] mr,
                         input logic [7:0] sb, input logic [31:0] dp,
                         input logic [63:0] nip, input string tag_ovr);
      @(negedge clk);
      check_pending();
      in_valid = 1'b1; long_mode = lm; asz_override = asz; rex_present = rp;
      rex_byte = rx; modrm = mr; sib = sb; disp = dp; next_ip = nip;
      model(lm, asz, rp, rx, mr, sb, dp, nip, e_ea, e_isr, e_ridx, e_rip, e_tag);
      if (tag_ovr != "") e_tag = tag_ovr;
      pend = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] sibs [4];
      sibs[0] = 8'h00; sibs[1] = 8'h24; sibs[2] = 8'hE5; sibs[3] = 8'h9D;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(out_valid === 1'b0, "R9", "reset valid", {63'd0, out_valid}, 64'd0);
      chk(out_ea === 64'd0, "R9", "reset address", out_ea, 64'd0);
      chk(out_is_reg === 1'b0 && out_reg_idx === 4'd0 && out_rip_rel === 1'b0,
          "R9", "reset flags", {58'd0, out_is_reg, out_reg_idx, out_rip_rel}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R9", "idle valid", {63'd0, out_valid}, 64'd0);

      // R6: register 13 with zero short displacement
      run_op(1'b1, 1'b0, 1'b1, 8'h41, 8'h45, 8'h00, 32'h0, 64'h1000, "R6");
      // R5: extended base bit does not turn the relative form into register 13
      run_op(1'b1, 1'b0, 1'b1, 8'h41, 8'h05, 8'h00, 32'hFFFF_FFF0,
             64'h0000_1234_0000_0008, "R5");

      for (int m = 0; m < 4; m++) begin
         for (int rv = 0; rv < 4; rv++) begin
            for (int mr = 0; mr < 256; mr++) begin
               for (int s = 0; s < 4; s++) begin
                  logic       rp;
                  logic [7:0] rx;
                  logic [31:0] dp;
                  case (rv)
                     0: begin rp = 1'b0; rx = 8'h4F; end
                     1: begin rp = 1'b1; rx = 8'h41; end
                     2: begin rp = 1'b1; rx = 8'h42; end
                     default: begin rp = 1'b1; rx = 8'h4B; end
                  endcase
                  dp = (mr[0] ^ s[0]) ? 32'h8765_43A1 : 32'h0123_4570;
                  run_op(m[1], m[0], rp, rx, 8'(mr), sibs[s], dp,
                         64'h0000_7FFF_FFFF_FF00, "");
               end
            end
         end
      end

      @(negedge clk);
      check_pending();
      in_valid = 1'b0;
      @(negedge clk);
      // R9: no strobe, no valid
      chk(out_valid === 1'b0, "R9", "valid after idle", {63'd0, out_valid}, 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule